// File: doc/BRIEF.md
# Zero-Sequence Offset Injector for Three-Phase Carrier PWM

The block takes three signed phase voltage references and the DC-link voltage once per switching period. It sorts the references into largest, middle and smallest and reports which of six 60-degree sectors the reference set lies in. It then chooses a distribution ratio mu between 0 and 1 from a selected modulation mode and computes a common-mode offset. The offset is added equally to all three phases, so line-to-line voltages are unchanged while the zero-state time is shared between the all-low and all-high switch states.

The modes cover continuous centred modulation (mu one half), two 120-degree clamped schemes (mu fixed at 0 or 1), and four 60-degree discontinuous schemes in which mu alternates between 0 and 1. The modified references feed a downstream carrier comparator that is not part of this block. Results appear one clock after an input strobe and are held until the next strobe.

Top module: `zero_seq_injector`

## Requirements
- R1: The phase chosen as maximum is a if a>=b and a>=c, else b if b>=c, else c; the phase chosen as minimum is c if c<=a and c<=b, else b if b<=a, else a; the remaining phase is the middle. `out_sector` encodes (max,min) as (a,c)=0, (b,c)=1, (b,a)=2, (c,a)=3, (c,b)=4, (a,b)=5.
- R2: mu is unsigned Q1.8 on `out_mu` (0, 128 or 256). Mode 0 and mode 7 give 128, mode 1 gives 0, mode 2 gives 256.
- R3: Mode 3 gives mu=256 when the middle reference is negative and 0 otherwise; mode 5 gives the complement (0 when negative, 256 otherwise).
- R4: Mode 4 gives mu=256 in even sectors (0, 2, 4) and 0 in odd sectors; mode 6 gives the complement.
- R5: With S = E*(128-mu) + mu*vmax + (256-mu)*vmin, the offset is vh = -floor((S+128)/256), saturated to the signed 16-bit range.
- R6: Each output equals its own reference plus the same vh, saturated to the signed 16-bit range.
- R7: `out_valid` is high exactly in the cycle after each cycle with `in_valid` high, and results belong to that strobe's inputs.
- R8: While `in_valid` is low, the data, sector and mu outputs keep their values whatever the inputs do.
- R9: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe, one per switching period |
| mode | input | 3 | Modulation mode select |
| ref_a | input | 16 | Phase a reference, signed |
| ref_b | input | 16 | Phase b reference, signed |
| ref_c | input | 16 | Phase c reference, signed |
| dc_link | input | 16 | DC-link voltage E, signed |
| out_valid | output | 1 | Result strobe |
| mod_a | output | 16 | Modified phase a reference |
| mod_b | output | 16 | Modified phase b reference |
| mod_c | output | 16 | Modified phase c reference |
| out_sector | output | 3 | Sector index 0..5 |
| out_mu | output | 9 | Applied distribution ratio, Q1.8 |

## Verification
The bench targets the sorting ties, where a design that compared with strict instead of non-strict inequality would name the same phase as both maximum and minimum or report the wrong sector. It covers a middle reference of exactly zero, which a design with the wrong sign test would place in the wrong half-sector and apply the opposite clamp. It checks rounding of an odd vmax+vmin sum, which a truncating design gets one count low. It drives inputs that overflow the offset and the per-phase sum, where a design without saturation would wrap to the opposite sign.

// File: rtl/zsi_pkg.sv
package zsi_pkg;
  typedef enum logic [2:0] {
    MODE_CENTRED  = 3'd0,
    MODE_CLAMP_LO = 3'd1,
    MODE_CLAMP_HI = 3'd2,
    MODE_DISC_MID = 3'd3,
    MODE_DISC_EDG = 3'd4,
    MODE_DISC_MDC = 3'd5,
    MODE_DISC_EDC = 3'd6,
    MODE_SPARE    = 3'd7
  } zsi_mode_e;

  localparam int NPH = 3;
endpackage

// File: rtl/zsi_sort.sv
module zsi_sort #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] ref_a,
  input  logic signed [DW-1:0] ref_b,
  input  logic signed [DW-1:0] ref_c,
  output logic signed [DW-1:0] v_max,
  output logic signed [DW-1:0] v_mid,
  output logic signed [DW-1:0] v_min,
  output logic [2:0]           sector
);
  logic signed [DW-1:0] v [zsi_pkg::NPH];
  logic [1:0] i_max, i_min, i_mid;

  assign v[0] = ref_a;
  assign v[1] = ref_b;
  assign v[2] = ref_c;

  always_comb begin
    if (ref_a >= ref_b && ref_a >= ref_c) i_max = 2'd0;
    else if (ref_b >= ref_c)              i_max = 2'd1;
    else                                  i_max = 2'd2;

    if (ref_c <= ref_a && ref_c <= ref_b) i_min = 2'd2;
    else if (ref_b <= ref_a)              i_min = 2'd1;
    else                                  i_min = 2'd0;

    i_mid = 2'd3 - i_max - i_min;

    case ({i_max, i_min})
      4'b00_10: sector = 3'd0;
      4'b01_10: sector = 3'd1;
      4'b01_00: sector = 3'd2;
      4'b10_00: sector = 3'd3;
      4'b10_01: sector = 3'd4;
      4'b00_01: sector = 3'd5;
      default:  sector = 3'd0;
    endcase
  end

  assign v_max = v[i_max];
  assign v_mid = v[i_mid];
  assign v_min = v[i_min];
endmodule

// File: rtl/zsi_mu_sched.sv
module zsi_mu_sched #(
  parameter int FRAC = 8
) (
  input  zsi_pkg::zsi_mode_e mode,
  input  logic [2:0]         sector,
  input  logic               mid_neg,
  output logic [FRAC:0]      mu
);
  import zsi_pkg::*;
  localparam logic [FRAC:0] MU_ZERO = '0;
  localparam logic [FRAC:0] MU_HALF = (FRAC+1)'(1 << (FRAC-1));
  localparam logic [FRAC:0] MU_ONE  = (FRAC+1)'(1 << FRAC);

  logic even_sec;
  assign even_sec = ~sector[0];

  always_comb begin
    case (mode)
      MODE_CLAMP_LO: mu = MU_ZERO;
      MODE_CLAMP_HI: mu = MU_ONE;
      MODE_DISC_MID: mu = mid_neg  ? MU_ONE  : MU_ZERO;
      MODE_DISC_EDG: mu = even_sec ? MU_ONE  : MU_ZERO;
      MODE_DISC_MDC: mu = mid_neg  ? MU_ZERO : MU_ONE;
      MODE_DISC_EDC: mu = even_sec ? MU_ZERO : MU_ONE;
      default:       mu = MU_HALF;
    endcase
  end
endmodule

// File: rtl/zsi_offset.sv
module zsi_offset #(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic signed [DW-1:0] dc_link,
  input  logic signed [DW-1:0] v_max,
  input  logic signed [DW-1:0] v_min,
  input  logic [FRAC:0]        mu,
  output logic signed [DW-1:0] vh
);
  localparam int WW = DW + FRAC + 4;
  localparam logic signed [WW-1:0] HALF_X = WW'(1 << (FRAC-1));
  localparam logic signed [WW-1:0] ONE_X  = WW'(1 << FRAC);
  localparam logic signed [WW-1:0] MAX_X  = WW'((1 << (DW-1)) - 1);
  localparam logic signed [WW-1:0] MIN_X  = -MAX_X - WW'(1);

  logic signed [WW-1:0] e_x, mx_x, mn_x, mu_x, acc, neg;

  always_comb begin
    e_x  = WW'(dc_link);
    mx_x = WW'(v_max);
    mn_x = WW'(v_min);
    mu_x = $signed(WW'({1'b0, mu}));
    acc  = e_x * (HALF_X - mu_x) + mx_x * mu_x + mn_x * (ONE_X - mu_x);
    neg  = -((acc + HALF_X) >>> FRAC);
    if (neg > MAX_X)      vh = MAX_X[DW-1:0];
    else if (neg < MIN_X) vh = MIN_X[DW-1:0];
    else                  vh = neg[DW-1:0];
  end
endmodule

// File: rtl/zero_seq_injector.sv
module zero_seq_injector #(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [2:0]           mode,
  input  logic signed [DW-1:0] ref_a,
  input  logic signed [DW-1:0] ref_b,
  input  logic signed [DW-1:0] ref_c,
  input  logic signed [DW-1:0] dc_link,
  output logic                 out_valid,
  output logic signed [DW-1:0] mod_a,
  output logic signed [DW-1:0] mod_b,
  output logic signed [DW-1:0] mod_c,
  output logic [2:0]           out_sector,
  output logic [FRAC:0]        out_mu
);
  import zsi_pkg::*;

  logic signed [DW-1:0] v_max, v_mid, v_min, vh;
  logic [2:0]           sec_nxt;
  logic [FRAC:0]        mu_nxt;
  logic signed [DW-1:0] ref_v   [NPH];
  logic signed [DW-1:0] mod_nxt [NPH];
  logic signed [DW-1:0] mod_q   [NPH];

  assign ref_v[0] = ref_a;
  assign ref_v[1] = ref_b;
  assign ref_v[2] = ref_c;

  zsi_sort #(.DW(DW)) i_sort (
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .v_max(v_max), .v_mid(v_mid), .v_min(v_min), .sector(sec_nxt)
  );

  zsi_mu_sched #(.FRAC(FRAC)) i_mu (
    .mode(zsi_mode_e'(mode)), .sector(sec_nxt),
    .mid_neg(v_mid[DW-1]), .mu(mu_nxt)
  );

  zsi_offset #(.DW(DW), .FRAC(FRAC)) i_off (
    .dc_link(dc_link), .v_max(v_max), .v_min(v_min), .mu(mu_nxt), .vh(vh)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic signed [DW:0] wide;
    always_comb begin
      wide = {ref_v[p][DW-1], ref_v[p]} + {vh[DW-1], vh};
      if (wide[DW] != wide[DW-1])
        mod_nxt[p] = wide[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
      else
        mod_nxt[p] = wide[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mod_q[p] <= '0;
      else if (in_valid) mod_q[p] <= mod_nxt[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sector <= '0;
      out_mu     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sector <= sec_nxt;
        out_mu     <= mu_nxt;
      end
    end
  end

  assign mod_a = mod_q[0];
  assign mod_b = mod_q[1];
  assign mod_c = mod_q[2];
endmodule

// File: rtl/zsi_checker.sv
module zsi_checker #(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [2:0]           mode,
  input logic                 out_valid,
  input logic signed [DW-1:0] mod_a,
  input logic signed [DW-1:0] mod_b,
  input logic signed [DW-1:0] mod_c,
  input logic [2:0]           out_sector,
  input logic [FRAC:0]        out_mu,
  input logic signed [DW-1:0] v_max,
  input logic signed [DW-1:0] v_mid,
  input logic signed [DW-1:0] v_min,
  input logic [FRAC:0]        mu_nxt
);
  assert_strobe_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_strobe_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(mod_a) && $stable(mod_b) && $stable(mod_c)
                   && $stable(out_sector) && $stable(out_mu)));

  assert_sector_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sector <= 3'd5);

  assert_sort_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (v_max >= v_mid) && (v_mid >= v_min));

  assert_mu_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mu_nxt));

  assert_clamp_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |-> (mu_nxt == '0));

  assert_disc_binary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode >= 3'd3 && mode <= 3'd6) |-> (mu_nxt[FRAC-1:0] == '0));
endmodule

bind zero_seq_injector zsi_checker #(.DW(DW), .FRAC(FRAC)) i_zsi_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
  .out_valid(out_valid), .mod_a(mod_a), .mod_b(mod_b), .mod_c(mod_c),
  .out_sector(out_sector), .out_mu(out_mu),
  .v_max(v_max), .v_mid(v_mid), .v_min(v_min), .mu_nxt(mu_nxt)
);

// File: tb/test_zero_seq_injector.sv
module test_zero_seq_injector;
  logic clk, rst_n, in_valid;
  logic [2:0] mode;
  logic signed [15:0] ref_a, ref_b, ref_c, dc_link;
  logic out_valid;
  logic signed [15:0] mod_a, mod_b, mod_c;
  logic [2:0] out_sector;
  logic [8:0] out_mu;

  int checks = 0;
  int fails  = 0;

  zero_seq_injector i_zero_seq_injector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c), .dc_link(dc_link),
    .out_valid(out_valid), .mod_a(mod_a), .mod_b(mod_b), .mod_c(mod_c),
    .out_sector(out_sector), .out_mu(out_mu)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [2:0]         md;
    logic signed [15:0] a;
    logic signed [15:0] b;
    logic signed [15:0] c;
    logic signed [15:0] e;
    logic [2:0]         sec;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{3'd0,  16'sd800,  -16'sd100, -16'sd700, 16'sd1000, 3'd0},
    '{3'd1,  16'sd100,   16'sd600, -16'sd700, 16'sd1000, 3'd1},
    '{3'd2, -16'sd700,   16'sd600,  16'sd100, 16'sd1000, 3'd2},
    '{3'd3, -16'sd700,   16'sd100,  16'sd600, 16'sd1000, 3'd3},
    '{3'd3, -16'sd200,  -16'sd600,  16'sd800, 16'sd1000, 3'd4},
    '{3'd4,  16'sd700,  -16'sd600, -16'sd100, 16'sd1000, 3'd5},
    '{3'd4,  16'sd700,   16'sd100, -16'sd800, 16'sd1000, 3'd0},
    '{3'd5,  16'sd700,   16'sd100, -16'sd800, 16'sd1000, 3'd0},
    '{3'd6, -16'sd700,   16'sd600,  16'sd100, 16'sd1000, 3'd2},
    '{3'd7,  16'sd100,   16'sd600, -16'sd700, 16'sd1000, 3'd1},
    '{3'd0,  16'sd0,     16'sd0,    16'sd0,   16'sd1000, 3'd0},
    '{3'd0, -16'sd300,  -16'sd300,  16'sd600, 16'sd1000, 3'd4},
    '{3'd2, -16'sd32000, 16'sd0,    16'sd32000, 16'sd30000, 3'd3},
    '{3'd2, -16'sd32768, -16'sd32768, -16'sd32768, 16'sd32767, 3'd0},
    '{3'd0,  16'sd5,     16'sd0,   -16'sd2,   16'sd1000, 3'd0},
    '{3'd5,  16'sd500,   16'sd0,   -16'sd500, 16'sd1000, 3'd0}
  };

  function automatic int sat16(input int x);
    if (x > 32767)  return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  // Model built from R1..R6
  task automatic model(input int md, input int a, input int b, input int c,
                       input int e, output int sec, output int mu,
                       output int oa, output int ob, output int oc);
    int imax, imin, vmax, vmin, vmid, s, vh;
    int v [3];
    v[0] = a; v[1] = b; v[2] = c;
    if (a >= b && a >= c) imax = 0; else if (b >= c) imax = 1; else imax = 2;
    if (c <= a && c <= b) imin = 2; else if (b <= a) imin = 1; else imin = 0;
    vmax = v[imax]; vmin = v[imin]; vmid = v[3 - imax - imin];
    if      (imax == 0 && imin == 2) sec = 0;
    else if (imax == 1 && imin == 2) sec = 1;
    else if (imax == 1 && imin == 0) sec = 2;
    else if (imax == 2 && imin == 0) sec = 3;
    else if (imax == 2 && imin == 1) sec = 4;
    else                             sec = 5;
    case (md)
      1: mu = 0;
      2: mu = 256;
      3: mu = (vmid < 0) ? 256 : 0;
      4: mu = (sec % 2 == 0) ? 256 : 0;
      5: mu = (vmid < 0) ? 0 : 256;
      6: mu = (sec % 2 == 0) ? 0 : 256;
      default: mu = 128;
    endcase
    s  = e * (128 - mu) + mu * vmax + (256 - mu) * vmin;
    vh = sat16(-((s + 128) >>> 8));
    oa = sat16(a + vh);
    ob = sat16(b + vh);
    oc = sat16(c + vh);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int md, input int a, input int b, input int c, input int e);
    mode = 3'(md); ref_a = 16'(a); ref_b = 16'(b); ref_c = 16'(c); dc_link = 16'(e);
    in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int es, em, ea, eb, ec;
    rst_n = 1'b0; in_valid = 1'b0; mode = '0;
    ref_a = '0; ref_b = '0; ref_c = '0; dc_link = '0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset values
    chk("R9 out_valid", out_valid, 0);
    chk("R9 mod_a", mod_a, 0);
    chk("R9 mod_b", mod_b, 0);
    chk("R9 mod_c", mod_c, 0);
    chk("R9 sector", out_sector, 0);
    chk("R9 mu", out_mu, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].md, VEC[i].a, VEC[i].b, VEC[i].c, VEC[i].e);
      model(VEC[i].md, VEC[i].a, VEC[i].b, VEC[i].c, VEC[i].e, es, em, ea, eb, ec);
      chk("R7 out_valid", out_valid, 1);
      chk("R1 sector table", out_sector, VEC[i].sec);
      chk("R1 sector model", out_sector, es);
      chk("R2 R3 R4 mu", out_mu, em);
      chk("R5 R6 mod_a", mod_a, ea);
      chk("R5 R6 mod_b", mod_b, eb);
      chk("R5 R6 mod_c", mod_c, ec);
    end

    // R7: strobe lasts one cycle only
    @(posedge clk); #1;
    chk("R7 out_valid low", out_valid, 0);

    // R8: new inputs without strobe leave outputs unchanged
    apply(2, 300, -200, -100, 1000);
    model(2, 300, -200, -100, 1000, es, em, ea, eb, ec);
    mode = 3'd1; ref_a = -16'sd900; ref_b = 16'sd900; ref_c = 16'sd0; dc_link = 16'sd500;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 out_valid", out_valid, 0);
    chk("R8 mod_a", mod_a, ea);
    chk("R8 mod_b", mod_b, eb);
    chk("R8 mod_c", mod_c, ec);
    chk("R8 sector", out_sector, es);
    chk("R8 mu", out_mu, em);

    // R5: rounding of odd vmax+vmin in centred mode, vh=-2
    apply(0, 5, 0, -2, 1000);
    chk("R5 rounding", mod_a, 3);

    // R3: zero middle counts as non-negative
    apply(3, 500, 0, -500, 1000);
    chk("R3 zero mid", out_mu, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule